// File: doc/BRIEF.md
# Word-Wide Bus Slave Decoder for a Chip Test Fixture

This block sits between a 16-bit-address, 16-bit-data backplane and a test fixture that drives a device under test (DUT). It watches the address lines A15 to A01, the six-bit address modifier and the address and data strobes. It claims a cycle only when the modifier carries the short-address, word-data code and the address lies in a 128-byte window at a base fixed by parameter. Every claimed cycle receives a data acknowledge. There is no A00 line, so each transfer is one 16-bit word and DUT port n answers at base + 2n.

Within the window, offset bit A06 sends a write to a pad-drive register and offset bit A05 sends a write to a clock-drive register. In both cases the remaining offset bits do not matter. A write with neither bit set goes to a numbered DUT port as a one-cycle strobe with its data. A read always returns the addressed DUT port. When the DUT has that output tristated, the read returns 0xFFFF, which software cannot tell apart from a driven 0xFFFF. All pins are plain level signals. The bus handshake is the strobe and acknowledge pair, so there is no valid/ready stream at this edge.

Top module: `vme_fixture_slave`

## Requirements
- R1: A cycle is claimed only while the address strobe is low and the address modifier equals 6'h29. Any other modifier gives no acknowledge and no data drive, and it changes no register or port.
- R2: Address bits A15..A07 are compared with the base, whose bit 15 is always forced to 1. With the default base 0xEE00, the addresses 0xEE00..0xEE7E are claimed and 0xEE80, 0xEDFE and 0x6E00 are not.
- R3: A claimed write with A06=0 and A05=0 pulses the bit of dut_wr_en selected by A04..A01 (port n at base+2n) for exactly one clock, with dut_wr_data equal to the bus data. The pulse and the acknowledge appear after the same edge.
- R4: A claimed write with A06=1 loads pad_drive from the bus data, whatever the other offset bits are. It strobes no port and leaves clk_drive unchanged.
- R5: A claimed write with A06=0 and A05=1 loads clk_drive from the bus data, whatever A04..A01 are. It strobes no port and leaves pad_drive unchanged.
- R6: A claimed write with both A06 and A05 high loads pad_drive only, and clk_drive keeps its value.
- R7: A claimed read returns the value of the DUT port selected by A04..A01, whatever A06 and A05 are, when dut_port_driven for that port is 1. Otherwise it returns 16'hFFFF. bus_data_oe is high only while a read is acknowledged, and bus_data_out is 0 when bus_data_oe is low.
- R8: bus_dtack_n goes low after the first clock edge at which a claimed cycle has the data strobe sampled low. It stays low while both strobes stay low, and it goes high after the first edge at which either strobe is high. A held strobe performs its access once only.
- R9: A synchronous reset clears pad_drive and clk_drive to 0, drives bus_dtack_n high and bus_data_oe low, and clears dut_wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixture clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 15 | Bus address bits A15..A01 |
| bus_am | input | 6 | Address modifier |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 1 | Data strobe, active low |
| bus_write_n | input | 1 | Low for a write, high for a read |
| bus_data_in | input | 16 | Write data from the bus |
| bus_data_out | output | 16 | Read data toward the bus |
| bus_data_oe | output | 1 | High while the read data is being driven |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| dut_port_data | input | 256 | Values of the 16 DUT ports, port n in bits 16n+15..16n |
| dut_port_driven | input | 16 | Per-port flag: 1 when the DUT drives that output |
| dut_wr_en | output | 16 | One-hot write strobe to the DUT ports |
| dut_wr_data | output | 16 | Data that goes with dut_wr_en |
| pad_drive | output | 16 | Pad-drive register |
| clk_drive | output | 16 | Clock-drive register |

## Verification
The stimulus walks writes to the lowest and highest ordinary ports, to pad addresses with and without the other offset bits set, to clock addresses, and to the address with both redirect bits set. This separates the port decode, the redirects and the priority between the two redirects. Accesses just outside the window, at a clear A15, and with wrong modifiers show that the window edges and the modifier match hold, and that nothing leaks into the registers. Reads of driven and tristated ports, one of them at an address with both redirect bits set, tell real data from the all-ones fill and show that reads are never redirected. Directed cases hold a strobe for several clocks and reset the block in the middle of operation.

// File: rtl/vme_fix_pkg.sv
package vme_fix_pkg;
  typedef enum logic [2:0] {
    ACC_READ    = 3'd0,
    ACC_PORT_WR = 3'd1,
    ACC_PAD_WR  = 3'd2,
    ACC_CLK_WR  = 3'd3
  } acc_kind_e;
endpackage

// File: rtl/vme_addr_match.sv
module vme_addr_match #(
  parameter logic [15:0] BASE_ADDR = 16'hEE00,
  parameter logic [5:0]  AM_CODE   = 6'h29
) (
  input  logic [15:1] addr,
  input  logic [5:0]  am,
  input  logic        as_n,
  output logic        hit
);
  localparam logic [8:0] BASE_HI = {1'b1, BASE_ADDR[14:7]};

  always_comb begin
    hit = !as_n && (am == AM_CODE) && (addr[15:7] == BASE_HI);
  end
endmodule

// File: rtl/vme_cycle_ctrl.sv
module vme_cycle_ctrl
  import vme_fix_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hit,
  input  logic      as_n,
  input  logic      ds_n,
  input  logic      write_n,
  input  logic      sel_pad,
  input  logic      sel_clk,
  output logic      fire,
  output acc_kind_e kind,
  output logic      ack
);
  logic ack_q;

  always_comb begin
    fire = hit && !ds_n && !ack_q;
    if (write_n)      kind = ACC_READ;
    else if (sel_pad) kind = ACC_PAD_WR;
    else if (sel_clk) kind = ACC_CLK_WR;
    else              kind = ACC_PORT_WR;
  end

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= fire || (ack_q && !ds_n && !as_n);
  end

  assign ack = ack_q;

  AST_ACK_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(hit)); // R1
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack_q && !ds_n && !as_n) |=> ack_q); // R8
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (ds_n || as_n) |=> !ack_q); // R8
endmodule

// File: rtl/vme_reg_bank.sv
module vme_reg_bank
  import vme_fix_pkg::*;
#(
  parameter int DW        = 16,
  parameter int NUM_PORTS = 16,
  localparam int IDX_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  acc_kind_e            kind,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DW-1:0]        wdata,
  output logic [NUM_PORTS-1:0] wr_en,
  output logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        pad_q,
  output logic [DW-1:0]        clk_q
);
  logic port_go;
  assign port_go = fire && (kind == ACC_PORT_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_q   <= '0;
      clk_q   <= '0;
      wr_data <= '0;
    end else begin
      if (fire && kind == ACC_PAD_WR) pad_q <= wdata;
      if (fire && kind == ACC_CLK_WR) clk_q <= wdata;
      if (port_go) wr_data <= wdata;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) wr_en[p] <= 1'b0;
      else     wr_en[p] <= port_go && (idx == p[IDX_W-1:0]);
    end
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en)); // R3
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|wr_en) |=> !(|wr_en)); // R3
  AST_PAD_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (fire && kind == ACC_PAD_WR) |=> $stable(clk_q)); // R6
endmodule

// File: rtl/vme_read_mux.sv
module vme_read_mux #(
  parameter int DW        = 16,
  parameter int NUM_PORTS = 16,
  localparam int IDX_W    = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS*DW-1:0] port_data,
  input  logic [NUM_PORTS-1:0]    port_driven,
  input  logic [IDX_W-1:0]        idx,
  output logic [DW-1:0]           rdata
);
  logic [DW-1:0] filled [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fill
    assign filled[p] = port_driven[p] ? port_data[p*DW +: DW] : {DW{1'b1}};
  end

  assign rdata = filled[idx];
endmodule

// File: rtl/vme_fixture_slave.sv
module vme_fixture_slave
  import vme_fix_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'hEE00,
  parameter logic [5:0]  AM_CODE   = 6'h29,
  parameter int          DW        = 16,
  parameter int          NUM_PORTS = 16,
  localparam int         IDX_W     = $clog2(NUM_PORTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [15:1]             bus_addr,
  input  logic [5:0]              bus_am,
  input  logic                    bus_as_n,
  input  logic                    bus_ds_n,
  input  logic                    bus_write_n,
  input  logic [DW-1:0]           bus_data_in,
  output logic [DW-1:0]           bus_data_out,
  output logic                    bus_data_oe,
  output logic                    bus_dtack_n,
  input  logic [NUM_PORTS*DW-1:0] dut_port_data,
  input  logic [NUM_PORTS-1:0]    dut_port_driven,
  output logic [NUM_PORTS-1:0]    dut_wr_en,
  output logic [DW-1:0]           dut_wr_data,
  output logic [DW-1:0]           pad_drive,
  output logic [DW-1:0]           clk_drive
);
  logic             hit;
  logic             fire;
  logic             ack;
  acc_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    mux_data;
  logic [DW-1:0]    rd_q;
  logic             oe_q;

  assign idx = bus_addr[IDX_W:1];

  vme_addr_match #(.BASE_ADDR(BASE_ADDR), .AM_CODE(AM_CODE)) u_match (
    .addr(bus_addr), .am(bus_am), .as_n(bus_as_n), .hit(hit)
  );

  vme_cycle_ctrl u_ctrl (
    .clk(clk), .rst(rst), .hit(hit), .as_n(bus_as_n), .ds_n(bus_ds_n),
    .write_n(bus_write_n), .sel_pad(bus_addr[6]), .sel_clk(bus_addr[5]),
    .fire(fire), .kind(kind), .ack(ack)
  );

  vme_reg_bank #(.DW(DW), .NUM_PORTS(NUM_PORTS)) u_regs (
    .clk(clk), .rst(rst), .fire(fire), .kind(kind), .idx(idx),
    .wdata(bus_data_in), .wr_en(dut_wr_en), .wr_data(dut_wr_data),
    .pad_q(pad_drive), .clk_q(clk_drive)
  );

  vme_read_mux #(.DW(DW), .NUM_PORTS(NUM_PORTS)) u_rmux (
    .port_data(dut_port_data), .port_driven(dut_port_driven),
    .idx(idx), .rdata(mux_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      oe_q <= 1'b0;
    end else begin
      if (fire && kind == ACC_READ) begin
        rd_q <= mux_data;
        oe_q <= 1'b1;
      end else if (bus_ds_n || bus_as_n) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign bus_data_out = oe_q ? rd_q : '0;
  assign bus_data_oe  = oe_q;
  assign bus_dtack_n  = !ack;

  AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |-> !bus_dtack_n); // R7
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_data_oe) |-> $past(hit && bus_write_n)); // R1
endmodule

// File: tb/test_vme_fixture_slave.sv
module test_vme_fixture_slave;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:1]  bus_addr = '0;
  logic [5:0]   bus_am = '0;
  logic         bus_as_n = 1'b1;
  logic         bus_ds_n = 1'b1;
  logic         bus_write_n = 1'b1;
  logic [15:0]  bus_data_in = '0;
  logic [15:0]  bus_data_out;
  logic         bus_data_oe;
  logic         bus_dtack_n;
  logic [255:0] dut_port_data;
  logic [15:0]  dut_port_driven = 16'h8029;
  logic [15:0]  dut_wr_en;
  logic [15:0]  dut_wr_data;
  logic [15:0]  pad_drive;
  logic [15:0]  clk_drive;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [15:0] m_pad = '0;
  logic [15:0] m_clk = '0;

  always #4 clk = ~clk;

  vme_fixture_slave i_vme_fixture_slave (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_am(bus_am),
    .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_write_n(bus_write_n),
    .bus_data_in(bus_data_in), .bus_data_out(bus_data_out),
    .bus_data_oe(bus_data_oe), .bus_dtack_n(bus_dtack_n),
    .dut_port_data(dut_port_data), .dut_port_driven(dut_port_driven),
    .dut_wr_en(dut_wr_en), .dut_wr_data(dut_wr_data),
    .pad_drive(pad_drive), .clk_drive(clk_drive)
  );

  function automatic logic [15:0] pval(int i);
    return (16'h0101 * i[15:0]) ^ 16'h5A00;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) dut_port_data[i*16 +: 16] = pval(i);
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {write, addr, am, data, claimed}
  localparam int NV = 17;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 16'hEE00, 6'h29, 16'h1111, 1'b1},
    {1'b1, 16'hEE1E, 6'h29, 16'h2222, 1'b1},
    {1'b1, 16'hEE40, 6'h29, 16'h3333, 1'b1},
    {1'b1, 16'hEE5E, 6'h29, 16'h4444, 1'b1},
    {1'b1, 16'hEE20, 6'h29, 16'h5555, 1'b1},
    {1'b1, 16'hEE3A, 6'h29, 16'h6666, 1'b1},
    {1'b1, 16'hEE60, 6'h29, 16'h7777, 1'b1},
    {1'b1, 16'hEE00, 6'h2D, 16'h8888, 1'b0},
    {1'b1, 16'hEE80, 6'h29, 16'h9999, 1'b0},
    {1'b1, 16'h6E00, 6'h29, 16'hAAAA, 1'b0},
    {1'b1, 16'hEDFE, 6'h29, 16'hBBBB, 1'b0},
    {1'b0, 16'hEE00, 6'h29, 16'h0000, 1'b1},
    {1'b0, 16'hEE04, 6'h29, 16'h0000, 1'b1},
    {1'b0, 16'hEE0A, 6'h29, 16'h0000, 1'b1},
    {1'b0, 16'hEE7E, 6'h29, 16'h0000, 1'b1},
    {1'b0, 16'hEE00, 6'h39, 16'h0000, 1'b0},
    {1'b0, 16'hEE08, 6'h29, 16'h0000, 1'b1}
  };

  task automatic start_cycle(input logic wr, input logic [15:0] a, input logic [5:0] am,
                             input logic [15:0] d);
    @(negedge clk);
    bus_addr = a[15:1];
    bus_am = am;
    bus_write_n = !wr;
    bus_data_in = d;
    bus_as_n = 1'b0;
    bus_ds_n = 1'b0;
  endtask

  task automatic end_cycle();
    @(negedge clk);
    bus_as_n = 1'b1;
    bus_ds_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset dtack", {15'd0, bus_dtack_n}, 16'd1);
    check("R9 reset oe", {15'd0, bus_data_oe}, 16'd0);
    check("R9 reset pad", pad_drive, 16'h0);
    check("R9 reset clk", clk_drive, 16'h0);
    check("R9 reset strobe", dut_wr_en, 16'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic wr, cl;
      logic [15:0] a, d, exp_en, exp_rd;
      wr = VEC[v][39];
      a  = VEC[v][38:23];
      d  = VEC[v][16:1];
      cl = VEC[v][0];
      exp_en = '0;
      exp_rd = dut_port_driven[a[4:1]] ? pval(int'(a[4:1])) : 16'hFFFF;
      if (wr && cl) begin
        if (a[6])      m_pad = d;
        else if (a[5]) m_clk = d;
        else           exp_en[a[4:1]] = 1'b1;
      end
      start_cycle(wr, a, VEC[v][22:17], d);
      @(posedge clk); #1;
      check(cl ? "R8 dtack on claim" : "R1/R2 no dtack", {15'd0, bus_dtack_n}, {15'd0, !cl});
      check("R3 port strobe", dut_wr_en, exp_en);
      if (exp_en != 0) check("R3 port data", dut_wr_data, d);
      check("R4 R6 pad reg", pad_drive, m_pad);
      check("R5 R6 clk reg", clk_drive, m_clk);
      if (!wr) begin
        check("R7 oe", {15'd0, bus_data_oe}, {15'd0, cl});
        check("R7 read data", bus_data_out, cl ? exp_rd : 16'h0);
      end
      @(posedge clk); #1;
      check("R3 strobe one cycle", dut_wr_en, 16'h0);
      end_cycle();
      check("R8 dtack release", {15'd0, bus_dtack_n}, 16'd1);
      check("R7 oe release", {15'd0, bus_data_oe}, 16'd0);
    end

    // Held strobe: one access, acknowledge stays.
    start_cycle(1'b1, 16'hEE06, 6'h29, 16'hC0DE);
    @(posedge clk); #1;
    check("R3 held first strobe", dut_wr_en, 16'h0008);
    repeat (3) begin
      @(posedge clk); #1;
      check("R8 held dtack", {15'd0, bus_dtack_n}, 16'd0);
      check("R8 single access", dut_wr_en, 16'h0);
    end
    @(negedge clk);
    bus_ds_n = 1'b1;
    @(posedge clk); #1;
    check("R8 ds release", {15'd0, bus_dtack_n}, 16'd1);
    end_cycle();

    // Driven all-ones value reads the same as a tristated port.
    dut_port_data[2*16 +: 16] = 16'hFFFF;
    dut_port_driven[2] = 1'b1;
    start_cycle(1'b0, 16'hEE04, 6'h29, 16'h0);
    @(posedge clk); #1;
    check("R7 driven ones", bus_data_out, 16'hFFFF);
    end_cycle();

    // Mid-run reset.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R9 reset pad clear", pad_drive, 16'h0);
    check("R9 reset clk clear", clk_drive, 16'h0);
    @(negedge clk);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule